// File: doc/BRIEF.md
# Rate-Limited Strobe Generator

This block drives the active-low handshake strobe that a sender toggles once per word during a synchronous data phase. Each accepted transfer request produces exactly one strobe pulse. The block keeps three timing bounds. The low (asserted) width has a minimum. The high (negated) gap between pulses has a minimum. The time from one falling (asserting) edge to the next has its own minimum. Because the third bound is measured edge to edge, a sender can never pack two narrow pulses close together and then pause to keep its average rate legal. Requests that arrive back to back are stretched out to the legal spacing.

A 2-bit speed mode picks the assertion width and the edge-to-edge period. The block samples the mode at the moment it accepts a request, so a later change in the mode does not affect a pulse that is already under way. The request side is a valid/ready handshake. Ready stays low while the strobe is asserted, and it stays low until both the negation minimum and the period minimum have run out. The asynchronous mode code is outside this block's job. Requests made in that mode are refused and flagged on an error output.

All timings are parameters in clock cycles. The defaults are: assertion width 2/2/3 cycles and period 3/5/10 cycles for the fastest, middle and slowest modes, with a negation minimum of 2 cycles in every mode.

Top module: `strobe_pacer`

## Requirements
- R1: While reset is held and on the first cycle after it is released, strobeN is 1 and pulseIssued is 0. modeError is also 0 at that point, and reqReady is 1 when speedMode selects a synchronous mode.
- R2: When reqValid and reqReady are both high at a rising clock edge, strobeN goes to 0 and pulseIssued goes to 1 right after that edge. pulseIssued is high for that single cycle only, and it never rises without a falling strobe.
- R3: The strobe stays low for exactly the assertion width of the mode that was sampled at acceptance. The mode codes are 2'b11 (fastest, 2 cycles by default), 2'b10 (middle, 2 cycles) and 2'b01 (slowest, 3 cycles).
- R4: After each pulse, the strobe stays high for at least NEG_CYC cycles (default 2) before the next assertion.
- R5: Two successive falling edges of strobeN are at least the period of the earlier pulse's mode apart. The defaults are 3, 5 and 10 cycles for codes 2'b11, 2'b10 and 2'b01. With requests held back to back, the spacing is exactly the larger of that period and the assertion width plus NEG_CYC.
- R6: reqReady is 0 whenever strobeN is 0, and it stays 0 until both the negation and the period minimum have expired.
- R7: A change of speedMode after a request has been accepted changes neither the width nor the period bound of that pulse.
- R8: With speedMode = 2'b00 (asynchronous), reqReady is 0 and no pulse is issued. modeError is 1 in the cycle after any cycle in which reqValid was high in that mode, and 0 otherwise.
- R9: With reqValid low, strobeN stays high and pulseIssued stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| speedMode | input | 2 | Speed mode: 11 fastest, 10 middle, 01 slowest, 00 asynchronous (refused) |
| reqValid | input | 1 | A transfer request is pending |
| reqReady | output | 1 | The block can accept a request this cycle |
| strobeN | output | 1 | Active-low handshake strobe |
| pulseIssued | output | 1 | One-cycle mark on the cycle the strobe falls |
| modeError | output | 1 | A request was presented in asynchronous mode in the previous cycle |

## Verification
The assertions assume the timing parameters are all at least one cycle. They also assume a requester that follows the handshake, meaning it counts a request as taken only on a cycle where reqValid and reqReady are both high. The stimulus changes speedMode and reqValid only on falling clock edges, so each rising edge sees stable inputs. The stimulus moves the mode in the middle of a pulse only after that pulse's request has been accepted. The asynchronous code is applied only for short bursts, after which the stimulus returns to a synchronous mode so that later pulses are checked against known timing.

// File: rtl/strobe_pacer_pkg.sv
package strobe_pacer_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SLOW  = 2'b01,
    MODE_FAST  = 2'b10,
    MODE_ULTRA = 2'b11
  } speed_e;

  // Strobes from control to the timer datapath.
  typedef struct packed {
    logic start;      // request accepted, strobe falls after this edge
    logic endAssert;  // strobe rises after this edge
  } pace_ctrl_t;

endpackage

// File: rtl/strobe_pacer_timers.sv
module strobe_pacer_timers
  import strobe_pacer_pkg::*;
#(
  parameter int ASSERT_ULTRA = 2,
  parameter int ASSERT_FAST  = 2,
  parameter int ASSERT_SLOW  = 3,
  parameter int PERIOD_ULTRA = 3,
  parameter int PERIOD_FAST  = 5,
  parameter int PERIOD_SLOW  = 10,
  parameter int NEG_CYC      = 2,
  parameter int CW           = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  pace_ctrl_t ctl,
  input  logic [1:0] speedMode,
  output logic       asrtLast,
  output logic       periodDone,
  output logic       negDone
);

  logic [CW-1:0] selA, selP;
  logic [CW-1:0] asrtLeft, periodLeft, negLeft;
  logic [CW-1:0] latchedP, sinceStart;
  logic          seenStart;

  always_comb begin
    case (speedMode)
      MODE_ULTRA: begin selA = CW'(ASSERT_ULTRA); selP = CW'(PERIOD_ULTRA); end
      MODE_FAST:  begin selA = CW'(ASSERT_FAST);  selP = CW'(PERIOD_FAST);  end
      default:    begin selA = CW'(ASSERT_SLOW);  selP = CW'(PERIOD_SLOW);  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asrtLeft   <= '0;
      periodLeft <= '0;
      latchedP   <= '0;
    end else if (ctl.start) begin
      asrtLeft   <= selA;
      periodLeft <= selP - CW'(1);
      latchedP   <= selP;
    end else begin
      if (asrtLeft != '0)   asrtLeft   <= asrtLeft - CW'(1);
      if (periodLeft != '0) periodLeft <= periodLeft - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              negLeft <= '0;
    else if (ctl.endAssert) negLeft <= CW'(NEG_CYC - 1);
    else if (negLeft != '0) negLeft <= negLeft - CW'(1);
  end

  assign asrtLast   = (asrtLeft == CW'(1));
  assign periodDone = (periodLeft == '0);
  assign negDone    = (negLeft == '0);

  // Edge-to-edge tracker, kept for the spacing check.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= '0;
      seenStart  <= 1'b0;
    end else if (ctl.start) begin
      sinceStart <= '0;
      seenStart  <= 1'b1;
    end else if (sinceStart != {CW{1'b1}}) begin
      sinceStart <= sinceStart + CW'(1);
    end
  end

  assert_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && seenStart) |-> (sinceStart >= latchedP - CW'(1)));

  assert_neg_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.endAssert |=> !ctl.start);

  assert_hold_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.start && !$past(ctl.start)) |-> $stable(latchedP));

endmodule

// File: rtl/strobe_pacer_ctrl.sv
module strobe_pacer_ctrl
  import strobe_pacer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] speedMode,
  input  logic       reqValid,
  input  logic       asrtLast,
  input  logic       periodDone,
  input  logic       negDone,
  output pace_ctrl_t ctl,
  output logic       reqReady,
  output logic       strobeN,
  output logic       pulseIssued,
  output logic       modeError
);

  logic active;
  logic modeOk;

  always_comb begin
    modeOk        = (speedMode != MODE_ASYNC);
    reqReady      = modeOk && !active && periodDone && negDone;
    ctl.start     = reqValid && reqReady;
    ctl.endAssert = active && asrtLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      pulseIssued <= 1'b0;
      modeError   <= 1'b0;
    end else begin
      if (ctl.start)          active <= 1'b1;
      else if (ctl.endAssert) active <= 1'b0;
      pulseIssued <= ctl.start;
      modeError   <= reqValid && !modeOk;
    end
  end

  assign strobeN = !active;

  assert_pulse_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    pulseIssued |-> (!strobeN && $past(strobeN)));

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    pulseIssued |=> !pulseIssued);

  assert_ready_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> !reqReady);

  assert_error_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    modeError |-> ($past(speedMode) == MODE_ASYNC && !pulseIssued));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> !pulseIssued);

endmodule

// File: rtl/strobe_pacer.sv
module strobe_pacer
  import strobe_pacer_pkg::*;
#(
  parameter int ASSERT_ULTRA = 2,
  parameter int ASSERT_FAST  = 2,
  parameter int ASSERT_SLOW  = 3,
  parameter int PERIOD_ULTRA = 3,
  parameter int PERIOD_FAST  = 5,
  parameter int PERIOD_SLOW  = 10,
  parameter int NEG_CYC      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] speedMode,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       strobeN,
  output logic       pulseIssued,
  output logic       modeError
);

  localparam int MAX_A = (ASSERT_ULTRA > ASSERT_FAST)
                       ? ((ASSERT_ULTRA > ASSERT_SLOW) ? ASSERT_ULTRA : ASSERT_SLOW)
                       : ((ASSERT_FAST > ASSERT_SLOW) ? ASSERT_FAST : ASSERT_SLOW);
  localparam int MAX_P = (PERIOD_ULTRA > PERIOD_FAST)
                       ? ((PERIOD_ULTRA > PERIOD_SLOW) ? PERIOD_ULTRA : PERIOD_SLOW)
                       : ((PERIOD_FAST > PERIOD_SLOW) ? PERIOD_FAST : PERIOD_SLOW);
  localparam int MAX_T = (MAX_A > MAX_P) ? ((MAX_A > NEG_CYC) ? MAX_A : NEG_CYC)
                                         : ((MAX_P > NEG_CYC) ? MAX_P : NEG_CYC);
  localparam int CW    = $clog2(MAX_T + 1) + 1;

  pace_ctrl_t ctl;
  logic       asrtLast, periodDone, negDone;

  strobe_pacer_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .speedMode  (speedMode),
    .reqValid   (reqValid),
    .asrtLast   (asrtLast),
    .periodDone (periodDone),
    .negDone    (negDone),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .strobeN    (strobeN),
    .pulseIssued(pulseIssued),
    .modeError  (modeError)
  );

  strobe_pacer_timers #(
    .ASSERT_ULTRA(ASSERT_ULTRA),
    .ASSERT_FAST (ASSERT_FAST),
    .ASSERT_SLOW (ASSERT_SLOW),
    .PERIOD_ULTRA(PERIOD_ULTRA),
    .PERIOD_FAST (PERIOD_FAST),
    .PERIOD_SLOW (PERIOD_SLOW),
    .NEG_CYC     (NEG_CYC),
    .CW          (CW)
  ) uTimers (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .speedMode (speedMode),
    .asrtLast  (asrtLast),
    .periodDone(periodDone),
    .negDone   (negDone)
  );

endmodule

// File: tb/strobe_pacer_test.sv
`timescale 1ns/1ps
module strobe_pacer_test;

  localparam int NEG = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] speedMode = 2'b11;
  logic       reqValid = 1'b0;
  logic       reqReady, strobeN, pulseIssued, modeError;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int fall; int width; } exp_t;
  exp_t q[$];

  int  lastF = 0, prevA = 0, prevP = 0;
  bit  haveLast = 1'b0;

  strobe_pacer #(
    .ASSERT_ULTRA(2), .ASSERT_FAST(2), .ASSERT_SLOW(3),
    .PERIOD_ULTRA(3), .PERIOD_FAST(5), .PERIOD_SLOW(10), .NEG_CYC(NEG)
  ) uut (
    .clk(clk), .rstN(rstN), .speedMode(speedMode), .reqValid(reqValid),
    .reqReady(reqReady), .strobeN(strobeN), .pulseIssued(pulseIssued),
    .modeError(modeError)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int widthOf(logic [1:0] m);
    case (m)
      2'b11: return 2;
      2'b10: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int periodOf(logic [1:0] m);
    case (m)
      2'b11: return 3;
      2'b10: return 5;
      default: return 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Driver: present count requests in mode m; optionally move the mode right after acceptance.
  task automatic sendReq(input logic [1:0] m, input int count, input bit doTwist,
                         input logic [1:0] twist);
    @(negedge clk);
    speedMode = m;
    reqValid  = 1'b1;
    for (int i = 0; i < count; i++) begin
      exp_t e;
      int   ex;
      ex = cyc + 1;
      if (haveLast) begin
        if (lastF + prevP > ex)       ex = lastF + prevP;        // R5 period bound
        if (lastF + prevA + NEG > ex) ex = lastF + prevA + NEG;  // R4 negation bound
      end
      e.fall  = ex;
      e.width = widthOf(m);
      q.push_back(e);
      lastF = ex; prevA = widthOf(m); prevP = periodOf(m); haveLast = 1'b1;
      #1;
      while (!reqReady) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      if (doTwist) speedMode = twist;  // R7: change mode during the pulse
    end
    reqValid = 1'b0;
  endtask

  // Monitor: pops expected pulses and compares fall cycle and width.
  int  fallCyc = 0, expW = 0;
  logic prevStrobe = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStrobe && !strobeN) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected pulse", cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.fall, "R5/R4 assertion edge cycle", cyc, e.fall);
          check(pulseIssued == 1'b1, "R2 pulseIssued on fall", pulseIssued, 1);
          check(reqReady == 1'b0, "R6 ready low while asserted", reqReady, 0);
          fallCyc = cyc;
          expW = e.width;
        end
      end else if (pulseIssued) begin
        check(1'b0, "R2 pulseIssued without fall", pulseIssued, 0);
      end
      if (!prevStrobe && strobeN)
        check(cyc - fallCyc == expW, "R3/R7 assertion width", cyc - fallCyc, expW);
      if (!strobeN && reqReady)
        check(1'b0, "R6 ready while asserted", reqReady, 0);
    end
    prevStrobe = strobeN;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(strobeN == 1'b1, "R1 strobe in reset", strobeN, 1);
    check(pulseIssued == 1'b0, "R1 pulse in reset", pulseIssued, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(strobeN == 1'b1, "R1 strobe after reset", strobeN, 1);
    check(modeError == 1'b0, "R1 error after reset", modeError, 0);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);

    // R2/R3: single pulse in the fastest mode
    sendReq(2'b11, 1, 1'b0, 2'b11);
    repeat (6) @(negedge clk);
    // R4: back-to-back in fastest mode, negation dominates (spacing 4)
    sendReq(2'b11, 4, 1'b0, 2'b11);
    repeat (6) @(negedge clk);
    // R5: back-to-back in middle mode, period dominates (spacing 5)
    sendReq(2'b10, 4, 1'b0, 2'b10);
    // R5: slowest mode right after, spacing from previous middle pulse, then 10
    sendReq(2'b01, 3, 1'b0, 2'b01);
    // R7: slow pulse, mode moved to fastest during it; next fast request waits the slow period
    sendReq(2'b01, 1, 1'b1, 2'b11);
    sendReq(2'b11, 2, 1'b0, 2'b11);
    repeat (12) @(negedge clk);

    // R8: asynchronous mode refused
    speedMode = 2'b00;
    reqValid  = 1'b1;
    #1;
    check(reqReady == 1'b0, "R8 ready in async mode", reqReady, 0);
    @(negedge clk);
    check(modeError == 1'b1, "R8 error raised", modeError, 1);
    check(strobeN == 1'b1, "R8 no pulse in async", strobeN, 1);
    reqValid = 1'b0;
    @(negedge clk);
    check(modeError == 1'b0, "R8 error cleared", modeError, 0);
    speedMode = 2'b11;

    // R9: idle with a valid mode
    repeat (20) @(negedge clk);
    check(strobeN == 1'b1, "R9 strobe idle", strobeN, 1);
    sendReq(2'b10, 1, 1'b0, 2'b10);
    repeat (30) @(negedge clk);
    check(q.size() == 0, "R2 all requests pulsed", q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule